// File: doc/BRIEF.md
# ADC Trigger Phase Alignment Controller

This block closes a loop between the compare value that fires an ADC pre-trigger and the instant the conversion really starts. A capture unit reports the period-timer value seen at the actual start of conversion. The controller compares that value with a setpoint held in the same timer ticks, and nudges the PWM timing until the two agree.

The conversion start is quantised to an arbitration slot of `SLOT_TICKS` timer ticks, so the correction runs in two stages. In the first stage the slot phase is fixed. While the setpoint and the captured value fall in different positions within a slot, each capture stretches nothing and shortens the next PWM period by one tick, which slips the timer against the slot grid. In the second stage the phase matches. The period returns to nominal, and one additive step moves the trigger compare by the whole-slot error that is left.

When a capture equals the setpoint, the controller raises its done flag and stops accepting captures. Loading a new setpoint clears the flag and arms the capture path again. The trigger compare starts from half the nominal period less `PRETRIG_SLOTS` slots. A timer that clears the trigger at -1 and sets it at this compare value is the consumer of the output.

Top module: `trig_align_ctrl`

## Requirements
- R1: After reset, `period_val` is `PERIOD_NOM` (default 4678), `trig_cmp` is `PERIOD_NOM/2 - PRETRIG_SLOTS*SLOT_TICKS` (default 2159), `aligned` is 0 and `cap_armed` is 0.
- R2: A `cap_strobe` is ignored in three cases: when `cap_armed` is 0, in the cycle right after an accepted capture, and in the same cycle as `sp_load`. An ignored capture changes neither `period_val` nor `trig_cmp` nor `aligned`.
- R3: Suppose an accepted capture whose value is not congruent with the stored setpoint modulo `SLOT_TICKS`. Then `period_val` becomes `PERIOD_NOM-1` after the second rising edge counted from the edge that sampled the strobe, and `trig_cmp` is unchanged.
- R4: Suppose an accepted capture that is congruent with the setpoint but not equal to it. Then `period_val` returns to `PERIOD_NOM`, and `trig_cmp` becomes its old value plus the setpoint minus the capture, on the same edge as in R3.
- R5: Suppose an accepted capture that equals the setpoint. Then `aligned` becomes 1, `cap_armed` becomes 0, `period_val` is `PERIOD_NOM`, and `trig_cmp` is unchanged.
- R6: The sum in R4 is clamped. A sum below 0 gives `trig_cmp` = 0, and a sum above `PERIOD_NOM` gives `trig_cmp` = `PERIOD_NOM`.
- R7: `sp_load` stores `sp_value`, sets `cap_armed` to 1 and clears `aligned` on the next edge. It leaves `period_val` and `trig_cmp` as they were.
- R8: When `sp_load` and `cap_strobe` are high in the same cycle, the load takes effect and the capture is discarded. A capture that is still waiting to be evaluated is also dropped.
- R9: Setpoint and capture are 16-bit two's complement. Congruence uses the mathematical residue, so -1 counts as 19 and -21 counts as 19 when `SLOT_TICKS` is 20.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sp_load | input | 1 | Load strobe for a new setpoint |
| sp_value | input | DATA_W | Setpoint in timer ticks, two's complement |
| cap_strobe | input | 1 | Capture event valid |
| cap_value | input | DATA_W | Timer value captured at conversion start, two's complement |
| period_val | output | DATA_W | Period reload value for the PWM timer |
| trig_cmp | output | DATA_W | Trigger compare value |
| aligned | output | 1 | Alignment reached for the current setpoint |
| cap_armed | output | 1 | Capture request source enabled |

## Verification
The two functions that can fall in one cycle are a setpoint load and a capture event. The bench drives `sp_load` and `cap_strobe` high on the same clock. It arranges the old setpoint so that evaluating the capture would visibly shorten the period. It then checks that the period and compare stay put and that the controller is armed. A following capture of the same value must then lock against the new setpoint, which confirms that the load won.

// File: rtl/trig_align_pkg.sv
package trig_align_pkg;

   // Outcome of evaluating one captured conversion-start time
   typedef enum logic [1:0] {
      ACT_SLIP  = 2'd0,   // slot phase differs: shorten the period by one tick
      ACT_SHIFT = 2'd1,   // phase matches: move the trigger compare
      ACT_LOCK  = 2'd2    // exact match: finish
   } align_act_e;

endpackage

// File: rtl/trig_residue.sv
// Remainder of a two's complement value by a constant slot length.
// The sign bit is flipped first (a fixed bias of 2^(W-1)), which turns the
// signed range into an unsigned one. Two values that share the same bias keep
// their congruence, so equality of the results means mathematical congruence.
module trig_residue #(
   parameter int DATA_W = 16,
   parameter int SLOT   = 20
) (
   input  logic [DATA_W-1:0]         value,
   output logic [$clog2(SLOT)-1:0]   residue
);
   localparam int RW = $clog2(SLOT);
   localparam logic [RW:0] SLOT_V = (RW+1)'(SLOT);

   generate
      if (SLOT < 2) begin : g_bad_slot
         $error("trig_residue: SLOT must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] biased;
   logic [RW:0]       rem_q [DATA_W+1];

   assign biased   = value ^ {1'b1, {(DATA_W-1){1'b0}}};
   assign rem_q[0] = '0;

   // One restoring step per bit, most significant bit first
   for (genvar i = 0; i < DATA_W; i++) begin : g_step
      logic [RW:0] shifted;
      assign shifted      = {rem_q[i][RW-1:0], biased[DATA_W-1-i]};
      assign rem_q[i+1]   = (shifted >= SLOT_V) ? (shifted - SLOT_V) : shifted;
   end

   assign residue = rem_q[DATA_W][RW-1:0];

endmodule

// File: rtl/trig_align_eval.sv
module trig_align_eval
   import trig_align_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int SLOT_TICKS = 20,
   parameter int PERIOD_NOM = 4678
) (
   input  logic [DATA_W-1:0] sp_lat,
   input  logic [DATA_W-1:0] cap_lat,
   input  logic [DATA_W-1:0] trig_cur,
   output align_act_e        action,
   output logic [DATA_W-1:0] trig_next
);
   localparam int RW = $clog2(SLOT_TICKS);
   localparam int XW = DATA_W + 2;
   localparam logic signed [XW-1:0] NOM_X = XW'(PERIOD_NOM);

   logic [RW-1:0] res_sp, res_cap;

   trig_residue #(.DATA_W(DATA_W), .SLOT(SLOT_TICKS)) u_res_sp (
      .value(sp_lat), .residue(res_sp));
   trig_residue #(.DATA_W(DATA_W), .SLOT(SLOT_TICKS)) u_res_cap (
      .value(cap_lat), .residue(res_cap));

   always_comb begin
      if (res_sp != res_cap)      action = ACT_SLIP;
      else if (sp_lat == cap_lat) action = ACT_LOCK;
      else                        action = ACT_SHIFT;
   end

   // Additive correction, widened so that neither the difference nor the sum wraps
   logic signed [XW-1:0] t_x, s_x, c_x, sum_x;
   assign t_x   = {2'b00, trig_cur};
   assign s_x   = {{2{sp_lat[DATA_W-1]}}, sp_lat};
   assign c_x   = {{2{cap_lat[DATA_W-1]}}, cap_lat};
   assign sum_x = t_x + s_x - c_x;

   always_comb begin
      if (sum_x < 0)          trig_next = '0;
      else if (sum_x > NOM_X) trig_next = DATA_W'(PERIOD_NOM);
      else                    trig_next = sum_x[DATA_W-1:0];
   end

endmodule

// File: rtl/trig_align_ctrl.sv
module trig_align_ctrl
   import trig_align_pkg::*;
#(
   parameter int DATA_W         = 16,
   parameter int SLOT_TICKS     = 20,
   parameter int PERIOD_NOM     = 4678,
   parameter int PRETRIG_SLOTS  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sp_load,
   input  logic [DATA_W-1:0] sp_value,
   input  logic              cap_strobe,
   input  logic [DATA_W-1:0] cap_value,
   output logic [DATA_W-1:0] period_val,
   output logic [DATA_W-1:0] trig_cmp,
   output logic              aligned,
   output logic              cap_armed
);
   localparam int TRIG_INIT = PERIOD_NOM/2 - PRETRIG_SLOTS*SLOT_TICKS;
   localparam logic [DATA_W-1:0] PER_NOM_V  = DATA_W'(PERIOD_NOM);
   localparam logic [DATA_W-1:0] PER_SLIP_V = DATA_W'(PERIOD_NOM - 1);
   localparam logic [DATA_W-1:0] TRIG_INIT_V = DATA_W'(TRIG_INIT);

   generate
      if (PERIOD_NOM < 2 || PERIOD_NOM >= (1 << (DATA_W-1))) begin : g_bad_period
         $error("trig_align_ctrl: PERIOD_NOM outside the positive timer range");
      end
      if (TRIG_INIT < 0) begin : g_bad_pretrig
         $error("trig_align_ctrl: pre-trigger exceeds half the period");
      end
   endgenerate

   logic [DATA_W-1:0] sp_reg, sp_lat, cap_lat, trig_next;
   logic              pend, accept;
   align_act_e        action;

   trig_align_eval #(
      .DATA_W(DATA_W), .SLOT_TICKS(SLOT_TICKS), .PERIOD_NOM(PERIOD_NOM)
   ) u_eval (
      .sp_lat(sp_lat), .cap_lat(cap_lat), .trig_cur(trig_cmp),
      .action(action), .trig_next(trig_next)
   );

   // One event in flight: a capture is taken only when armed and idle
   assign accept = cap_strobe && cap_armed && !pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_reg     <= '0;
         sp_lat     <= '0;
         cap_lat    <= '0;
         pend       <= 1'b0;
         period_val <= PER_NOM_V;
         trig_cmp   <= TRIG_INIT_V;
         aligned    <= 1'b0;
         cap_armed  <= 1'b0;
      end else if (sp_load) begin
         // New setpoint wins over any capture activity in this cycle
         sp_reg    <= sp_value;
         pend      <= 1'b0;
         aligned   <= 1'b0;
         cap_armed <= 1'b1;
      end else begin
         pend <= accept;
         if (accept) begin
            sp_lat  <= sp_reg;
            cap_lat <= cap_value;
         end
         if (pend) begin
            unique case (action)
               ACT_SLIP:  period_val <= PER_SLIP_V;
               ACT_SHIFT: begin
                  period_val <= PER_NOM_V;
                  trig_cmp   <= trig_next;
               end
               default: begin
                  period_val <= PER_NOM_V;
                  aligned    <= 1'b1;
                  cap_armed  <= 1'b0;
               end
            endcase
         end
      end
   end

   AST_TRIG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      trig_cmp <= PER_NOM_V);                                              // R6
   AST_DONE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      aligned |-> !cap_armed);                                             // R5
   AST_LOAD_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
      sp_load |=> (cap_armed && !aligned));                                // R7
   AST_IDLE_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      !pend |=> $stable(trig_cmp));                                        // R2
   AST_IDLE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      !pend |=> $stable(period_val));                                      // R3
   AST_PERIOD_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (period_val == PER_NOM_V) || (period_val == PER_SLIP_V));            // R4

endmodule

// File: tb/trig_align_ctrl_test.sv
module trig_align_ctrl_test;
   localparam int NOM  = 4678;
   localparam int INIT = NOM/2 - 9*20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sp_load = 1'b0;
   logic [15:0] sp_value = '0;
   logic        cap_strobe = 1'b0;
   logic [15:0] cap_value = '0;
   logic [15:0] period_val, trig_cmp;
   logic        aligned, cap_armed;

   always #5 clk = ~clk;

   trig_align_ctrl uut (
      .clk(clk), .rst_n(rst_n), .sp_load(sp_load), .sp_value(sp_value),
      .cap_strobe(cap_strobe), .cap_value(cap_value), .period_val(period_val),
      .trig_cmp(trig_cmp), .aligned(aligned), .cap_armed(cap_armed));

   int n_run = 0, n_fail = 0;
   int e_per = NOM, e_trig = INIT, e_al = 0, e_en = 0, sp_m = 0;
   bit finished = 0;

   function automatic int mod20(int v);
      return ((v % 20) + 20) % 20;
   endfunction

   function automatic int clampv(int v);
      if (v < 0) return 0;
      if (v > NOM) return NOM;
      return v;
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_all(string req);
      chk(req, "period_val", int'(period_val), e_per);
      chk(req, "trig_cmp", int'(trig_cmp), e_trig);
      chk(req, "aligned", int'(aligned), e_al);
      chk(req, "cap_armed", int'(cap_armed), e_en);
   endtask

   task automatic model_cap(int c);
      if (e_en == 0) return;
      if (mod20(sp_m) != mod20(c)) e_per = NOM - 1;
      else begin
         e_per = NOM;
         if (sp_m == c) begin e_al = 1; e_en = 0; end
         else e_trig = clampv(e_trig + sp_m - c);
      end
   endtask

   task automatic do_load(int s);
      @(negedge clk); sp_load = 1'b1; sp_value = 16'(s);
      @(negedge clk); sp_load = 1'b0;
      @(negedge clk);
      sp_m = s; e_en = 1; e_al = 0;
   endtask

   task automatic do_cap(int c);
      @(negedge clk); cap_strobe = 1'b1; cap_value = 16'(c);
      @(negedge clk); cap_strobe = 1'b0;
      @(negedge clk);
      model_cap(c);
   endtask

   task automatic t_reset;
      check_all("R1");
   endtask

   task automatic t_ignored_unarmed;
      do_cap(55);
      check_all("R2");
   endtask

   task automatic t_slip;
      do_load(2300);
      check_all("R7");
      do_cap(2301);
      check_all("R3");
   endtask

   task automatic t_shift;
      do_cap(2260);
      check_all("R4");
   endtask

   task automatic t_lock;
      do_cap(2300);
      check_all("R5");
      do_cap(2000);
      check_all("R2");
   endtask

   task automatic t_back_to_back;
      // Second strobe lands while the first is evaluated: it must be dropped
      do_load(40);
      @(negedge clk); cap_strobe = 1'b1; cap_value = 16'(41);
      @(negedge clk); cap_value = 16'(20);
      @(negedge clk); cap_strobe = 1'b0;
      @(negedge clk);
      model_cap(41);
      check_all("R2");
   endtask

   task automatic t_clamp_hi;
      do_load(16000);
      do_cap(0);
      check_all("R6");
   endtask

   task automatic t_negative;
      do_load(-1);
      do_cap(-2);
      check_all("R9");
      do_cap(19);
      check_all("R9");
      do_cap(-21);
      check_all("R9");
   endtask

   task automatic t_collision;
      // Old setpoint -1 against capture 100 would slip the period
      @(negedge clk);
      sp_load = 1'b1; sp_value = 16'(100);
      cap_strobe = 1'b1; cap_value = 16'(100);
      @(negedge clk); sp_load = 1'b0; cap_strobe = 1'b0;
      @(negedge clk); @(negedge clk);
      sp_m = 100; e_en = 1; e_al = 0;
      check_all("R8");
      do_cap(100);
      check_all("R8");
   endtask

   task automatic t_clamp_lo;
      do_load(-20000);
      do_cap(0);
      check_all("R6");
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ignored_unarmed();
      t_slip();
      t_shift();
      t_lock();
      t_back_to_back();
      t_clamp_hi();
      t_negative();
      t_collision();
      t_clamp_lo();
      summary();
   end

   initial begin
      #200000;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

endmodule